// File: doc/BRIEF.md
# Fuzzy Neutral-Point Offset Controller

This block sits in the control path of a three-level neutral-point-clamped inverter. It keeps the two DC-link capacitors at equal voltage. Each time a new pair of capacitor voltage samples arrives with a strobe, the block works out the imbalance (upper minus lower) and how far that imbalance has moved since the last accepted sample. It then runs both quantities through a small fuzzy inference engine and produces a signed offset. That offset is added to all three phase modulation references upstream of the carrier comparators.

Each input is fuzzified with evenly spaced triangular sets. The spacing of each input is set as a power-of-two shift. The rule matrix is fixed and deliberately asymmetric:
- While the imbalance is changing, it drives a strong correction.
- While the imbalance is steady, it backs the correction off.

Rule strengths weight singleton output levels, which are spaced by a programmable step. A bit-serial divider forms the weighted average, and the result is clamped to a programmable magnitude. Results appear a fixed number of cycles after the strobe, marked by a one-cycle valid pulse.

Top module: `npb_fuzzy_ctrl`

## Requirements
- R1: On an accepted strobe the error is `v_hi - v_lo` (signed), and the change is that error minus the error of the previously accepted strobe. The first strobe accepted after reset uses a change of zero.
- R2: The error has five sets with indices 0..4, meaning NB, NS, ZE, PS, PB. Set k is centred at `(k-2) << e_shift` raw counts and is a triangle one spacing wide on each side. Errors beyond the outer centres give full membership to NB or PB. Full membership is `2**MW`.
- R3: The change has three sets with indices 0..2, meaning NB, ZE, PB. Set j is centred at `(j-1) << c_shift`, with the same triangle shape and saturation as R2.
- R4: The rule output set is chosen as follows. When the change set is NB or PB, the output set equals the error set. When the change set is ZE, error sets NB, NS, ZE, PS, PB give output sets NB, ZE, ZE, ZE, PS.
- R5: Each rule has a strength equal to the minimum of its two memberships. Output set m has the singleton value `(m-2)*out_step`. The offset is the strength-weighted average of the singletons, truncated toward zero. It is zero when the total strength is zero.
- R6: The offset is clamped to the range `[-ofs_lim, +ofs_lim]`.
- R7: `ofs_vld` is a one-cycle pulse. It appears 2+MW+OW+5 rising edges after the edge that accepts the strobe (27 with default parameters), and `ofs` changes only on that pulse.
- R8: A strobe that arrives while a computation is in progress is ignored. It produces no result and does not change the stored previous error.
- R9: During reset and directly after reset, `ofs` is 0 and `ofs_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Sample strobe, one cycle |
| v_hi | input | VW | Upper capacitor voltage sample, unsigned |
| v_lo | input | VW | Lower capacitor voltage sample, unsigned |
| e_shift | input | SHW | Log2 of the error set spacing |
| c_shift | input | SHW | Log2 of the change set spacing |
| out_step | input | OW-1 | Spacing of the output singletons |
| ofs_lim | input | OW-1 | Magnitude limit of the offset |
| ofs | output | OW | Signed offset correction |
| ofs_vld | output | 1 | One-cycle pulse when `ofs` is updated |

## Verification
If the stored previous error is wrong, the error does not show at once. It shows one result later, as a wrong change set, and most clearly when two equal samples in a row fail to land on the change-ZE row of the rules. A fuzzifier or rule-table fault shows in the very next result, with the wrong magnitude or sign. Asymmetric pairs such as +24 and -24 with a steady change expose a mirrored rule matrix. A divider or sequencing fault shows as a wrong quotient, or as the valid pulse landing on any cycle other than the fixed latency. An ignored strobe that leaks into the state shows in the result that follows it.

// File: rtl/npb_pkg.sv
package npb_pkg;
  localparam int N_ERR = 5;
  localparam int N_CHG = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_DIV} npb_st_e;

  // Output set for error set e (0..4) and change set c (0..2).
  function automatic int rule_out(int e, int c);
    if (c != 1) return e;
    case (e)
      0: return 0;
      4: return 3;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/npb_fuzzify.sv
module npb_fuzzify #(
  parameter int XW    = 13,
  parameter int MW    = 8,
  parameter int SHW   = 4,
  parameter int NSETS = 5
) (
  input  logic signed [XW-1:0]    x_i,
  input  logic [SHW-1:0]          sh_i,
  output logic [NSETS-1:0][MW:0]  mu_o
);
  localparam int H  = (NSETS - 1) / 2;
  localparam int QW = XW + MW + 1;
  localparam logic signed [QW-1:0] QMAX = QW'(H * (2 ** MW));
  localparam logic [MW:0] FULL = {1'b1, {MW{1'b0}}};

  logic signed [QW-1:0] q_ext, q_scl, q_raw, q_cl, idx;
  logic [MW-1:0]        frac;
  int                   base;

  always_comb begin
    q_ext = QW'(x_i);
    q_scl = q_ext <<< MW;
    q_raw = q_scl >>> sh_i;
    if (q_raw > QMAX)       q_cl = QMAX;
    else if (q_raw < -QMAX) q_cl = -QMAX;
    else                    q_cl = q_raw;
    idx  = q_cl >>> MW;
    frac = q_cl[MW-1:0];
    base = int'(idx) + H;
  end

  for (genvar k = 0; k < NSETS; k++) begin : g_set
    assign mu_o[k] = (base == k)     ? (FULL - {1'b0, frac}) :
                     (base == k - 1) ? {1'b0, frac} : '0;
  end
endmodule

// File: rtl/npb_rules.sv
module npb_rules #(
  parameter int MW = 8,
  parameter int OW = 12,
  parameter int NW = 25,
  parameter int DW = 13
) (
  input  logic [npb_pkg::N_ERR-1:0][MW:0] mue_i,
  input  logic [npb_pkg::N_CHG-1:0][MW:0] muc_i,
  input  logic [OW-2:0]                   step_i,
  output logic signed [NW-1:0]            num_o,
  output logic [DW-1:0]                   den_o
);
  localparam int NR  = npb_pkg::N_ERR * npb_pkg::N_CHG;
  localparam int CXW = OW + 2;

  logic [MW:0]             w    [NR];
  logic signed [NW-1:0]    term [NR];
  logic signed [CXW-1:0]   st_s;

  assign st_s = $signed({3'b000, step_i});

  for (genvar e = 0; e < npb_pkg::N_ERR; e++) begin : g_e
    for (genvar c = 0; c < npb_pkg::N_CHG; c++) begin : g_c
      localparam int M = npb_pkg::rule_out(e, c);
      localparam logic signed [2:0] MUL = 3'(M - 2);
      logic signed [CXW-1:0] cen;
      assign w[e*npb_pkg::N_CHG+c] = (mue_i[e] < muc_i[c]) ? mue_i[e] : muc_i[c];
      assign cen = st_s * CXW'(MUL);
      assign term[e*npb_pkg::N_CHG+c] =
        NW'($signed({1'b0, w[e*npb_pkg::N_CHG+c]})) * NW'(cen);
    end
  end

  always_comb begin
    num_o = '0;
    den_o = '0;
    for (int i = 0; i < NR; i++) begin
      num_o = num_o + term[i];
      den_o = den_o + DW'(w[i]);
    end
  end
endmodule

// File: rtl/npb_div.sv
module npb_div #(
  parameter int NW = 25,
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [NW-1:0] dvd_i,
  input  logic [DW-1:0] dvs_i,
  output logic [NW-1:0] quo_o,
  output logic          done_o
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q_q, q_d;
  logic [DW-1:0] r_q, r_d, d_q, d_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, done_q, done_d;
  logic [DW:0]   trial;

  always_comb begin
    q_d = q_q; r_d = r_q; d_d = d_q; cnt_d = cnt_q;
    busy_d = busy_q; done_d = 1'b0;
    trial = {r_q, q_q[NW-1]};
    if (start_i) begin
      q_d = dvd_i; r_d = '0; d_d = dvs_i; cnt_d = '0; busy_d = 1'b1;
    end else if (busy_q) begin
      if (trial >= {1'b0, d_q}) begin
        r_d = DW'(trial - {1'b0, d_q});
        q_d = {q_q[NW-2:0], 1'b1};
      end else begin
        r_d = trial[DW-1:0];
        q_d = {q_q[NW-2:0], 1'b0};
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(NW - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0; r_q <= '0; d_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      q_q <= q_d; r_q <= r_d; d_q <= d_d; cnt_q <= cnt_d;
      busy_q <= busy_d; done_q <= done_d;
    end
  end

  assign quo_o  = q_q;
  assign done_o = done_q;

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/npb_fuzzy_ctrl.sv
module npb_fuzzy_ctrl #(
  parameter int VW  = 12,
  parameter int MW  = 8,
  parameter int OW  = 12,
  parameter int SHW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic [VW-1:0]        v_hi,
  input  logic [VW-1:0]        v_lo,
  input  logic [SHW-1:0]       e_shift,
  input  logic [SHW-1:0]       c_shift,
  input  logic [OW-2:0]        out_step,
  input  logic [OW-2:0]        ofs_lim,
  output logic signed [OW-1:0] ofs,
  output logic                 ofs_vld
);
  import npb_pkg::*;

  localparam int EW = VW + 1;
  localparam int CW = VW + 2;
  localparam int NW = MW + OW + 5;
  localparam int DW = MW + 5;
  localparam int unsigned FULLI = 2 ** MW;

  logic [1:0] rsync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  npb_st_e st_q, st_d;
  logic signed [EW-1:0] err_q, err_d, err_new;
  logic signed [CW-1:0] chg_q, chg_d, chg_new;
  logic                 primed_q, primed_d, neg_q, neg_d, dnz_q, dnz_d;
  logic signed [OW-1:0] ofs_q, ofs_d, res;
  logic                 vld_q, vld_d;

  logic [N_ERR-1:0][MW:0] mue;
  logic [N_CHG-1:0][MW:0] muc;
  logic signed [NW-1:0]   num;
  logic [DW-1:0]          den;
  logic [NW-1:0]          num_mag, quo;
  logic                   div_start, div_done;
  logic [OW-2:0]          cm;

  npb_fuzzify #(.XW(EW), .MW(MW), .SHW(SHW), .NSETS(N_ERR)) u_fz_err (
    .x_i(err_q), .sh_i(e_shift), .mu_o(mue));
  npb_fuzzify #(.XW(CW), .MW(MW), .SHW(SHW), .NSETS(N_CHG)) u_fz_chg (
    .x_i(chg_q), .sh_i(c_shift), .mu_o(muc));
  npb_rules #(.MW(MW), .OW(OW), .NW(NW), .DW(DW)) u_rules (
    .mue_i(mue), .muc_i(muc), .step_i(out_step), .num_o(num), .den_o(den));
  npb_div #(.NW(NW), .DW(DW)) u_div (
    .clk(clk), .rst_n(rst_s), .start_i(div_start), .dvd_i(num_mag),
    .dvs_i(den), .quo_o(quo), .done_o(div_done));

  always_comb begin
    err_new = $signed({1'b0, v_hi}) - $signed({1'b0, v_lo});
    chg_new = CW'(err_new) - CW'(err_q);
    num_mag = num[NW-1] ? NW'(-num) : NW'(num);
    cm      = (quo > NW'(ofs_lim)) ? ofs_lim : quo[OW-2:0];
    if (!dnz_q)     res = '0;
    else if (neg_q) res = -$signed({1'b0, cm});
    else            res = $signed({1'b0, cm});
  end

  always_comb begin
    st_d = st_q; err_d = err_q; chg_d = chg_q; primed_d = primed_q;
    neg_d = neg_q; dnz_d = dnz_q; ofs_d = ofs_q; vld_d = 1'b0;
    div_start = 1'b0;
    case (st_q)
      ST_IDLE: if (smp_vld) begin
        err_d    = err_new;
        chg_d    = primed_q ? chg_new : '0;
        primed_d = 1'b1;
        st_d     = ST_EVAL;
      end
      ST_EVAL: begin
        div_start = 1'b1;
        neg_d     = num[NW-1];
        dnz_d     = (den != '0);
        st_d      = ST_DIV;
      end
      ST_DIV: if (div_done) begin
        ofs_d = res;
        vld_d = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= ST_IDLE; err_q <= '0; chg_q <= '0; primed_q <= 1'b0;
      neg_q <= 1'b0; dnz_q <= 1'b0; ofs_q <= '0; vld_q <= 1'b0;
    end else begin
      st_q <= st_d; err_q <= err_d; chg_q <= chg_d; primed_q <= primed_d;
      neg_q <= neg_d; dnz_q <= dnz_d; ofs_q <= ofs_d; vld_q <= vld_d;
    end
  end

  assign ofs     = ofs_q;
  assign ofs_vld = vld_q;

  // R2
  err_mu_sum_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (DW'(mue[0]) + DW'(mue[1]) + DW'(mue[2]) + DW'(mue[3]) + DW'(mue[4]))
      == DW'(FULLI));
  // R3
  chg_mu_sum_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (DW'(muc[0]) + DW'(muc[1]) + DW'(muc[2])) == DW'(FULLI));
  // R5
  den_live_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_EVAL) |-> (den != '0));
  // R6
  ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ofs_vld |-> ((ofs <= $signed({1'b0, ofs_lim})) &&
                 (ofs >= -$signed({1'b0, ofs_lim}))));
  // R7
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ofs_vld |=> !ofs_vld);
  // R7
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !ofs_vld |-> $stable(ofs));
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (smp_vld && st_q != ST_IDLE) |=> $stable(err_q));
endmodule

// File: tb/tb_npb_fuzzy_ctrl.sv
module tb_npb_fuzzy_ctrl;
  localparam int VW = 12, MW = 8, OW = 12, SHW = 4;
  localparam int LAT  = MW + OW + 5 + 2;
  localparam longint FULL = 64'd1 << MW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [VW-1:0] v_hi = '0, v_lo = '0;
  logic [SHW-1:0] e_shift = 4'd4, c_shift = 4'd4;
  logic [OW-2:0] out_step = 11'd100, ofs_lim = 11'd1023;
  logic signed [OW-1:0] ofs;
  logic ofs_vld;

  always #10ns clk = ~clk;

  npb_fuzzy_ctrl #(.VW(VW), .MW(MW), .OW(OW), .SHW(SHW)) dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .v_hi(v_hi), .v_lo(v_lo),
    .e_shift(e_shift), .c_shift(c_shift), .out_step(out_step),
    .ofs_lim(ofs_lim), .ofs(ofs), .ofs_vld(ofs_vld));

  typedef struct { longint v; longint c; string t; } exp_t;
  exp_t sb[$];
  int total = 0, bad = 0;
  longint cyc = 0;
  longint prev_err = 0;
  bit primed = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint mu(longint x, int sh, int k, int h);
    longint q, d;
    q = (x <<< MW) >>> sh;
    if (q > h * FULL) q = h * FULL;
    if (q < -h * FULL) q = -h * FULL;
    d = q - (k - h) * FULL;
    if (d < 0) d = -d;
    d = FULL - d;
    return (d > 0) ? d : 0;
  endfunction

  function automatic int oset(int e, int c);
    int zrow [5] = '{0, 2, 2, 2, 3};
    return (c == 1) ? zrow[e] : e;
  endfunction

  function automatic longint model(longint hi, longint lo);
    longint err, chg, num, den, w, mag, lim;
    err = hi - lo;
    chg = primed ? err - prev_err : 0;
    prev_err = err;
    primed = 1;
    num = 0; den = 0;
    for (int e = 0; e < 5; e++)
      for (int c = 0; c < 3; c++) begin
        longint a, b;
        a = mu(err, int'(e_shift), e, 2);
        b = mu(chg, int'(c_shift), c, 1);
        w = (a < b) ? a : b;
        num += w * (oset(e, c) - 2) * longint'(out_step);
        den += w;
      end
    if (den == 0) return 0;
    mag = ((num < 0) ? -num : num) / den;
    lim = longint'(ofs_lim);
    if (mag > lim) mag = lim;
    return (num < 0) ? -mag : mag;
  endfunction

  task automatic send(int hi, int lo, string tag);
    exp_t x;
    @(negedge clk);
    v_hi = VW'(hi); v_lo = VW'(lo); smp_vld = 1'b1;
    x.v = model(hi, lo); x.c = cyc + 1 + LAT; x.t = tag;
    sb.push_back(x);
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (LAT + 2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && ofs_vld) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8 unexpected result", longint'(ofs), 0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        chk(longint'(ofs) == x.v, x.t, longint'(ofs), x.v);
        chk(cyc == x.c, "R7 latency", cyc, x.c);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    prev_err = 0; primed = 0;
    repeat (3) @(negedge clk);
    chk(ofs == '0, "R9 ofs in reset", longint'(ofs), 0);
    chk(ofs_vld == 1'b0, "R9 vld in reset", longint'(ofs_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ofs == '0, "R9 ofs after reset", longint'(ofs), 0);
    chk(ofs_vld == 1'b0, "R9 vld after reset", longint'(ofs_vld), 0);
  endtask

  initial begin
    #(20ns * 150000);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: first sample after reset, change forced to zero
    send(1000, 1000, "R1 balanced first sample");
    send(1000, 976, "R2 PS/PB split, change PB");
    send(1000, 976, "R4 steady +24 gives ZE/PS row");
    send(900, 1000, "R2 saturated NB");
    send(990, 1000, "R5 fractional weighted average");
    send(976, 1000, "R1 change from previous error");
    send(976, 1000, "R4 steady -24 asymmetric row");
    // R6: clamp
    ofs_lim = 11'd120;
    send(1400, 1000, "R6 clamp positive");
    send(600, 1000, "R6 clamp negative");
    send(1010, 1000, "R6 inside limit");
    ofs_lim = 11'd2047;
    // R3, R5: other spacings
    e_shift = 4'd6; c_shift = 4'd2; out_step = 11'd37;
    for (int i = 0; i < 14; i++)
      send(1900 + i * 23, 2048, "R3 sweep");
    // R8: strobe while busy is ignored
    e_shift = 4'd4; c_shift = 4'd4; out_step = 11'd100;
    send(1500, 1400, "R5 before busy strobe");
    @(negedge clk);
    v_hi = 12'd1500; v_lo = 12'd1400; smp_vld = 1'b1;
    begin
      exp_t x;
      x.v = model(1500, 1400); x.c = cyc + 1 + LAT; x.t = "R8 base";
      sb.push_back(x);
    end
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (5) @(negedge clk);
    v_hi = 12'd4095; v_lo = 12'd0; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    send(1500, 1400, "R8 previous error untouched");
    // R1: reset clears previous error
    do_reset();
    send(1100, 1000, "R1 change zero after reset");
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R7 all results seen", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule